// File: doc/BRIEF.md
# Quadrature NCO with Weighted Sinusoid Output

This block is the oscillator half of a digital phase-locked loop. A 32-bit phase accumulator adds a programmable increment on every enabled clock, so the oscillation frequency is f_clk / 2^32 * phase_inc. The top 12 accumulator bits address a quarter-wave sine table. From one table the block reads four values: the cosine and sine of the accumulator phase, and the cosine and sine of a separate feedback phase. The feedback pair goes back to the loop's phase detector.

In second-harmonic mode the feedback phase is the accumulator phase shifted right by one bit. The feedback pair then turns at half the rate of the accumulator. When the loop locks that half-rate pair to an input, the output sinusoid sits at twice the input frequency.

The output stage builds one real sinusoid of any amplitude and phase. It multiplies the full-phase cosine and sine by two signed 8-bit weights, sums the products, scales the sum by 1/128 and clamps the result to the signed 14-bit range. A weight of 127 corresponds to full scale. The conversion from amplitude and phase to the two weights is done outside the block.

Top module: `quad_nco_mix`

## Requirements
- R1: A synchronous active-low reset clears the accumulator and drives `fb_cos`, `fb_sin` and `out_sample` to 0. Reset takes priority over `ce`.
- R2: On every rising edge with `ce` high and reset released, the accumulator adds `phase_inc`. The table angle k (0..4095) is accumulator bits [31:20].
- R3: Table values are signed 14-bit. The sine of angle k is round(8191 * sin(2*pi*(k+0.5)/4096)), and the cosine of k is the sine of (k+1024) mod 4096.
- R4: With `harm2_en` low, the feedback angle equals the accumulator angle.
- R5: With `harm2_en` high, the feedback angle is {0, accumulator bits [31:21]}, so `fb_sin` is never negative. The output stage still uses the full accumulator angle.
- R6: `out_sample` = floor((wc*cos(k) + ws*sin(k)) / 128), where wc and ws are the two's-complement values of `wt_cos` and `wt_sin`.
- R7: The weighted result saturates to the range [-8192, 8191] instead of wrapping.
- R8: The feedback outputs show an accumulator update one enabled clock later, and `out_sample` shows it three enabled clocks later. A weight change presented before edge n appears on `out_sample` after edge n+1.
- R9: While `ce` is low, the accumulator, `fb_cos`, `fb_sin` and `out_sample` all hold. Changes on `phase_inc`, the weights and `harm2_en` have no effect until `ce` returns.
- R10: The accumulator wraps modulo 2^32 without any discontinuity in the table angle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable for the accumulator and all pipeline stages |
| phase_inc | input | 32 | Phase step added per enabled clock |
| harm2_en | input | 1 | Selects the half-rate feedback phase (second-harmonic mode) |
| wt_cos | input | 8 | Signed weight applied to the cosine |
| wt_sin | input | 8 | Signed weight applied to the sine |
| fb_cos | output | 14 | Signed cosine of the feedback phase |
| fb_sin | output | 14 | Signed sine of the feedback phase |
| out_sample | output | 14 | Signed weighted output sample |

## Verification
The bench targets the following corner cases, each of which a specific design error would break:

- **Accumulator wrap:** a wrap across 2^32 must land on the correct table angle. A carry or width error would jump to the wrong point on the wave.
- **45-degree saturation:** a point where both weighted parts add past full scale must clamp. A design that wraps would flip the output to the opposite sign.
- **Second-harmonic angles:** in this mode the feedback pair must come from the halved angle while the output keeps the full angle. Swapping the two paths, or using an arithmetic shift, would move the feedback into the wrong half-plane.
- **Latency and clock enable:** the bench counts the exact clocks to the outputs after a phase step and after a weight step, and it holds `ce` low while changing every other input. An extra or missing register stage, or an ungated stage, would show a shifted edge or a moved output.

// File: rtl/nco_pkg.sv
// Package nco_pkg
// Shared helper for the oscillator. Computes one quarter-wave sine magnitude
// at elaboration time using only integer fixed-point arithmetic.
// Assumes addr_bits <= 12, so that every intermediate fits in 64 bits.
package nco_pkg;

    localparam longint PI_Q30 = 64'sd3373259426;

    // Returns round(peak * sin(pi*(2*idx+1) / 2^(addr_bits+2))) from a Taylor series in Q30.
    function automatic int quarter_sine(input int idx, input int addr_bits, input int peak);
        longint x;
        longint term;
        longint sum;
        x    = (longint'(2 * idx + 1) * PI_Q30) >>> (addr_bits + 2);
        term = x;
        sum  = x;
        for (int n = 1; n <= 9; n++) begin
            term = (term * x) >>> 30;
            term = (term * x) >>> 30;
            term = -(term / longint'((2 * n) * (2 * n + 1)));
            sum  = sum + term;
        end
        return int'((sum * longint'(peak) + (longint'(1) <<< 29)) >>> 30);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
// Module nco_phase_acc
// Phase accumulator. Adds phase_inc on every enabled clock and exports only
// the top ANG_W bits, which address the wave table.
// Assumes a synchronous active-low reset; the sum wraps modulo 2^PHASE_W.
module nco_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int ANG_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce,
    input  logic [PHASE_W-1:0] phase_inc,
    output logic [ANG_W-1:0]   angle
);

    logic [PHASE_W-1:0] acc;

    // Advance the phase by the increment while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (ce) begin
            acc <= acc + phase_inc;
        end
    end

    assign angle = acc[PHASE_W-1 -: ANG_W];

    // R2: an enabled nonzero step always moves the phase.
    a_r2_acc_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && (phase_inc != '0)) |=> (acc != $past(acc)));

endmodule

// File: rtl/nco_quad_lut.sv
// Module nco_quad_lut
// One quarter-wave magnitude table with four registered read paths: cosine
// and sine of the main angle, and cosine and sine of the feedback angle.
// Assumes a half-step angle offset, so the table has no zero entry and the
// quadrant folding is exact; the stored peak is 2^(AMP_W-1)-1.
module nco_quad_lut #(
    parameter int LUT_AW = 10,
    parameter int AMP_W  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce,
    input  logic [LUT_AW+1:0]       main_ang,
    input  logic [LUT_AW+1:0]       fb_ang,
    output logic signed [AMP_W-1:0] main_cos,
    output logic signed [AMP_W-1:0] main_sin,
    output logic signed [AMP_W-1:0] fb_cos,
    output logic signed [AMP_W-1:0] fb_sin
);

    localparam int ANG_W  = LUT_AW + 2;
    localparam int QDEPTH = 1 << LUT_AW;
    localparam int PEAK   = (1 << (AMP_W - 1)) - 1;
    localparam logic [ANG_W-1:0] QUARTER = ANG_W'(QDEPTH);

    logic [AMP_W-2:0] rom [QDEPTH];

    // Build the magnitude table, one constant entry per address.
    for (genvar g = 0; g < QDEPTH; g++) begin : g_rom
        localparam int VAL = nco_pkg::quarter_sine(g, LUT_AW, PEAK);
        assign rom[g] = (AMP_W - 1)'(VAL);
    end

    // Fold a full-circle angle onto the quarter table and restore the sign.
    function automatic logic signed [AMP_W-1:0] wave_at(input logic [ANG_W-1:0] ang);
        logic [LUT_AW-1:0] idx;
        logic [AMP_W-1:0]  mag;
        idx = ang[ANG_W-2] ? ~ang[LUT_AW-1:0] : ang[LUT_AW-1:0];
        mag = {1'b0, rom[idx]};
        return ang[ANG_W-1] ? -$signed(mag) : $signed(mag);
    endfunction

    logic signed [AMP_W-1:0] mc_n, ms_n, fc_n, fs_n;

    // Four table reads; each cosine is the sine a quarter turn ahead.
    always_comb begin
        ms_n = wave_at(main_ang);
        mc_n = wave_at(main_ang + QUARTER);
        fs_n = wave_at(fb_ang);
        fc_n = wave_at(fb_ang + QUARTER);
    end

    // Register the four read results while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_cos <= '0;
            main_sin <= '0;
            fb_cos   <= '0;
            fb_sin   <= '0;
        end else if (ce) begin
            main_cos <= mc_n;
            main_sin <= ms_n;
            fb_cos   <= fc_n;
            fb_sin   <= fs_n;
        end
    end

endmodule

// File: rtl/nco_weight_mix.sv
// Module nco_weight_mix
// Two-stage output mixer. Registers the two weighted products, then
// registers their sum scaled by 2^-(WT_W-1) and clamped to AMP_W bits.
// Assumes signed inputs; the scaling rounds toward minus infinity.
module nco_weight_mix #(
    parameter int AMP_W = 14,
    parameter int WT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce,
    input  logic signed [AMP_W-1:0] wave_cos,
    input  logic signed [AMP_W-1:0] wave_sin,
    input  logic signed [WT_W-1:0]  wt_cos,
    input  logic signed [WT_W-1:0]  wt_sin,
    output logic signed [AMP_W-1:0] sample
);

    localparam int PROD_W = AMP_W + WT_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam int SHIFT  = WT_W - 1;
    localparam logic signed [SUM_W-1:0] OUT_MAX = SUM_W'((1 <<< (AMP_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] OUT_MIN = SUM_W'(-(1 <<< (AMP_W - 1)));

    logic signed [PROD_W-1:0] prod_c, prod_s;
    logic signed [SUM_W-1:0]  sum_w, scaled, clamped;

    // Stage one: weight each quadrature component.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_c <= '0;
            prod_s <= '0;
        end else if (ce) begin
            prod_c <= PROD_W'(wave_cos) * PROD_W'(wt_cos);
            prod_s <= PROD_W'(wave_sin) * PROD_W'(wt_sin);
        end
    end

    // Add, scale down and clamp to the output range.
    always_comb begin
        sum_w  = {prod_c[PROD_W-1], prod_c} + {prod_s[PROD_W-1], prod_s};
        scaled = sum_w >>> SHIFT;
        if (scaled > OUT_MAX) begin
            clamped = OUT_MAX;
        end else if (scaled < OUT_MIN) begin
            clamped = OUT_MIN;
        end else begin
            clamped = scaled;
        end
    end

    // Stage two: register the output sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
        end else if (ce) begin
            sample <= clamped[AMP_W-1:0];
        end
    end

    // R7: two non-negative parts never produce a negative sample.
    a_r7_pos_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !prod_c[PROD_W-1] && !prod_s[PROD_W-1]) |=> !sample[AMP_W-1]);

    // R7: two negative parts never produce a non-negative sample.
    a_r7_neg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && prod_c[PROD_W-1] && prod_s[PROD_W-1]) |=> sample[AMP_W-1]);

endmodule

// File: rtl/quad_nco_mix.sv
// Module quad_nco_mix
// Top level: phase accumulator, feedback phase select (full rate or half
// rate), shared wave table and weighted output stage.
// Assumes one enable for the whole datapath. Latency from an accumulator
// update is 1 clock to the feedback pair and 3 clocks to out_sample.
module quad_nco_mix #(
    parameter int PHASE_W = 32,
    parameter int LUT_AW  = 10,
    parameter int AMP_W   = 14,
    parameter int WT_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce,
    input  logic [PHASE_W-1:0]      phase_inc,
    input  logic                    harm2_en,
    input  logic signed [WT_W-1:0]  wt_cos,
    input  logic signed [WT_W-1:0]  wt_sin,
    output logic signed [AMP_W-1:0] fb_cos,
    output logic signed [AMP_W-1:0] fb_sin,
    output logic signed [AMP_W-1:0] out_sample
);

    localparam int ANG_W = LUT_AW + 2;

    logic [ANG_W-1:0]        main_ang, fb_ang;
    logic signed [AMP_W-1:0] main_cos, main_sin;

    nco_phase_acc #(
        .PHASE_W (PHASE_W),
        .ANG_W   (ANG_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .phase_inc (phase_inc),
        .angle     (main_ang)
    );

    // Feedback angle: full phase, or phase/2 in second-harmonic mode.
    always_comb begin
        fb_ang = harm2_en ? {1'b0, main_ang[ANG_W-1:1]} : main_ang;
    end

    nco_quad_lut #(
        .LUT_AW (LUT_AW),
        .AMP_W  (AMP_W)
    ) u_lut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .main_ang (main_ang),
        .fb_ang   (fb_ang),
        .main_cos (main_cos),
        .main_sin (main_sin),
        .fb_cos   (fb_cos),
        .fb_sin   (fb_sin)
    );

    nco_weight_mix #(
        .AMP_W (AMP_W),
        .WT_W  (WT_W)
    ) u_mix (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .wave_cos (main_cos),
        .wave_sin (main_sin),
        .wt_cos   (wt_cos),
        .wt_sin   (wt_sin),
        .sample   (out_sample)
    );

    // R9: with the enable low, every output holds its value.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(out_sample) && $stable(fb_cos) && $stable(fb_sin)));

    // R5: the half-rate feedback angle stays in the upper half-plane.
    a_r5_fb_half_plane: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && harm2_en) |=> !fb_sin[AMP_W-1]);

endmodule

// File: tb/quad_nco_mix_tb.sv
module quad_nco_mix_tb;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               ce;
    logic [31:0]        phase_inc;
    logic               harm2_en;
    logic signed [7:0]  wt_cos, wt_sin;
    logic signed [13:0] fb_cos, fb_sin, out_sample;

    int          checks   = 0;
    int          failures = 0;
    bit          done     = 1'b0;
    logic [31:0] acc_m    = '0;

    always #4 clk = ~clk;

    quad_nco_mix u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce         (ce),
        .phase_inc  (phase_inc),
        .harm2_en   (harm2_en),
        .wt_cos     (wt_cos),
        .wt_sin     (wt_sin),
        .fb_cos     (fb_cos),
        .fb_sin     (fb_sin),
        .out_sample (out_sample)
    );

    // Reference model, written from the requirements.
    function automatic int tsin(input int k);
        real r;
        r = 8191.0 * $sin(6.283185307179586 * (real'(k % 4096) + 0.5) / 4096.0);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
    endfunction

    function automatic int tcos(input int k);
        return tsin((k + 1024) % 4096);
    endfunction

    function automatic int kof(input logic [31:0] a);
        return int'(a[31:20]);
    endfunction

    function automatic int mix(input int k, input int wc, input int ws);
        longint p;
        p = longint'(wc) * tcos(k) + longint'(ws) * tsin(k);
        p = p >>> 7;
        if (p > 8191)  p = 8191;
        if (p < -8192) p = -8192;
        return int'(p);
    endfunction

    task automatic chk(input string tag, input int act, input int exp, input int tol);
        checks++;
        if ((act - exp > tol) || (exp - act > tol)) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_w(input int wc, input int ws);
        wt_cos = 8'(wc);
        wt_sin = 8'(ws);
    endtask

    // Move the accumulator to target in one step, then let the pipeline settle.
    task automatic settle(input logic [31:0] target);
        phase_inc = target - acc_m;
        tick();
        phase_inc = '0;
        acc_m     = target;
        repeat (4) tick();
    endtask

    // R1: clears during reset, reset wins over ce, restart from phase 0.
    task automatic t_reset();
        repeat (3) tick();
        chk("R1 fb_cos in reset", int'(fb_cos), 0, 0);
        chk("R1 fb_sin in reset", int'(fb_sin), 0, 0);
        chk("R1 out in reset", int'(out_sample), 0, 0);
        rst_n     = 1'b1;
        phase_inc = '0;
        set_w(40, -40);
        acc_m = '0;
        repeat (4) tick();
        chk("R1 fb_cos at phase 0", int'(fb_cos), tcos(0), 1);
        chk("R1 fb_sin at phase 0", int'(fb_sin), tsin(0), 1);
        chk("R1 out at phase 0", int'(out_sample), mix(0, 40, -40), 2);
    endtask

    // R2: continuous fractional stepping, feedback tracks one clock behind.
    task automatic t_sweep();
        phase_inc = 32'h0013_3333;
        for (int i = 0; i < 10; i++) begin
            tick();
            chk("R2 sweep fb_sin", int'(fb_sin), tsin(kof(acc_m)), 1);
            acc_m = acc_m + 32'h0013_3333;
        end
        phase_inc = '0;
    endtask

    // R3, R4, R6: static points across all quadrants, several weight pairs.
    task automatic t_static();
        logic [31:0] pts [5];
        int          wcs [5];
        int          wss [5];
        pts = '{32'h0000_0000, 32'h2345_6789, 32'h6000_0000, 32'hA987_6543, 32'hE000_0000};
        wcs = '{100, -70, 0, 55, -128};
        wss = '{0, 33, 127, -90, 12};
        harm2_en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            set_w(wcs[i], wss[i]);
            settle(pts[i]);
            chk("R3 R4 fb_cos", int'(fb_cos), tcos(kof(acc_m)), 1);
            chk("R3 R4 fb_sin", int'(fb_sin), tsin(kof(acc_m)), 1);
            chk("R6 weighted out", int'(out_sample), mix(kof(acc_m), wcs[i], wss[i]), 2);
        end
    endtask

    // R10: a step across 2^32 lands at angle 256.
    task automatic t_wrap();
        set_w(100, 0);
        settle(32'hF000_0000);
        phase_inc = 32'h2000_0000;
        tick();
        phase_inc = '0;
        acc_m = acc_m + 32'h2000_0000;
        repeat (4) tick();
        chk("R10 wrap fb_sin", int'(fb_sin), tsin(256), 1);
        chk("R10 wrap out", int'(out_sample), mix(256, 100, 0), 2);
    endtask

    // R5: feedback uses the halved angle; the output keeps the full angle.
    task automatic t_harm();
        set_w(0, 64);
        harm2_en = 1'b1;
        settle(32'h8000_0000);
        chk("R5 half fb_cos", int'(fb_cos), tcos(1024), 1);
        chk("R5 half fb_sin", int'(fb_sin), tsin(1024), 1);
        chk("R5 full out", int'(out_sample), mix(2048, 0, 64), 2);
        settle(32'hC000_0000);
        chk("R5 half fb_sin 3q", int'(fb_sin), tsin(1536), 1);
        chk("R5 full out 3q", int'(out_sample), mix(3072, 0, 64), 2);
        harm2_en = 1'b0;
        tick();
        chk("R4 back to full fb_sin", int'(fb_sin), tsin(3072), 1);
    endtask

    // R7: a 45-degree point overflows both ways and must clamp.
    task automatic t_sat();
        settle(32'h2000_0000);
        set_w(127, 127);
        repeat (3) tick();
        chk("R7 clamp high", int'(out_sample), 8191, 0);
        set_w(-128, -128);
        repeat (3) tick();
        chk("R7 clamp low", int'(out_sample), -8192, 0);
    endtask

    // R8: exact clocks from a phase step to the feedback and output ports.
    task automatic t_latency();
        int old_out;
        int old_fc;
        set_w(100, 0);
        settle(32'h0000_0000);
        old_out   = int'(out_sample);
        old_fc    = int'(fb_cos);
        phase_inc = 32'h8000_0000;
        tick();
        phase_inc = '0;
        acc_m     = 32'h8000_0000;
        chk("R8 fb unchanged at edge 0", int'(fb_cos), old_fc, 0);
        tick();
        chk("R8 fb updated at edge 1", int'(fb_cos), tcos(2048), 1);
        chk("R8 out unchanged at edge 1", int'(out_sample), old_out, 0);
        tick();
        chk("R8 out unchanged at edge 2", int'(out_sample), old_out, 0);
        tick();
        chk("R8 out updated at edge 3", int'(out_sample), mix(2048, 100, 0), 2);
    endtask

    // R8: a weight change reaches the output one edge after it is sampled.
    task automatic t_weights();
        set_w(-60, 0);
        tick();
        chk("R8 weight not yet visible", int'(out_sample), mix(2048, 100, 0), 2);
        tick();
        chk("R8 weight visible", int'(out_sample), mix(2048, -60, 0), 2);
    endtask

    // R9: with ce low, every input change is ignored and the phase holds.
    task automatic t_ce();
        int o_out;
        int o_c;
        int o_s;
        o_out     = int'(out_sample);
        o_c       = int'(fb_cos);
        o_s       = int'(fb_sin);
        ce        = 1'b0;
        phase_inc = 32'h4000_0000;
        set_w(20, 90);
        harm2_en  = 1'b1;
        repeat (5) tick();
        chk("R9 out held", int'(out_sample), o_out, 0);
        chk("R9 fb_cos held", int'(fb_cos), o_c, 0);
        chk("R9 fb_sin held", int'(fb_sin), o_s, 0);
        phase_inc = '0;
        harm2_en  = 1'b0;
        ce        = 1'b1;
        repeat (4) tick();
        chk("R9 phase did not advance", int'(fb_cos), tcos(kof(acc_m)), 1);
        chk("R9 new weights after resume", int'(out_sample), mix(kof(acc_m), 20, 90), 2);
    endtask

    initial begin
        rst_n     = 1'b0;
        ce        = 1'b1;
        harm2_en  = 1'b0;
        phase_inc = 32'h1234_5678;
        wt_cos    = '0;
        wt_sin    = '0;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_static();
        t_wrap();
        t_harm();
        t_sat();
        t_latency();
        t_weights();
        t_ce();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule